// File: doc/BRIEF.md
# Prime-Field Column Permutation Address Generator

This block produces the within-row column permutation of a prime-based rectangular turbo-code interleaver. It builds the permutation with adders and comparators only, with no multiplier and no divider anywhere in the datapath. After a start strobe it latches a prime `p`, a primitive root `v` of that prime, a row count `R` and a column count `C`. It then works through two phases.

In the preparation phase, a bit-serial shift-and-add unit fills a local table with the base sequence `s(0)=1, s(k) = v*s(k-1) mod p` for k = 0..p-2. Then each row's increment `q(i)` is fetched through a small lookup port and reduced modulo `p-1` by repeated subtraction. In the output phase, one column index comes out per clock. Column 0 is emitted for all rows, then column 1, and so on. Each row keeps its own running table address in a ring of per-row registers. That address advances by the row's reduced increment, with one add and one conditional subtract modulo `p-1`. A single-cycle done pulse closes the block. A neighbouring block supplies the `q(i)` values and consumes the indices.

Top module: `iam_addr_gen`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, `idx_valid_o` and `done_o` are low.
- R2: The index emitted for row i and column j equals `s(a)`, where `a = (j*q(i)) mod (p-1)`, `s(0)=1` and `s(k) = (v*s(k-1)) mod p`. Every emitted index therefore lies in 1..p-1.
- R3: Each increment is reduced modulo p-1 before use. This holds for q = 0, for q equal to p-1 or to a multiple of it (such a row emits 1 in every column), and for q larger than 2(p-1).
- R4: Indices come column by column. Within a column the rows run 0,1,..,R-1, and `idx_row_o` carries the row number of each index.
- R5: Once the first index appears, `idx_valid_o` stays high for exactly R*C consecutive cycles.
- R6: `done_o` is high for exactly one cycle. That is the cycle right after the last valid index, and `idx_valid_o` is low in it.
- R7: A start strobe that arrives while a job is in progress has no effect. Neither the emitted sequence nor its length changes, even if the configuration inputs change at the same time.
- R8: A start strobe given in the cycle where `done_o` is high is accepted. It begins a new job with the configuration present in that cycle.
- R9: C may exceed p-1 (up to p+1). For such columns the recursion keeps running, so column j gives the same index as column j-(p-1).
- R10: During the preparation phase, `q_row_o` presents row numbers 0..R-1 in order, and `q_val_i` is taken as the raw increment of the presented row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a job; accepted only when idle |
| prime_i | input | PW | Prime p, sampled at start |
| root_i | input | PW | Primitive root v of p, sampled at start |
| rows_i | input | RW | Row count R (1..MAX_ROWS), sampled at start |
| cols_i | input | CW | Column count C (1..p+1), sampled at start |
| q_row_o | output | RW | Row whose raw increment is requested |
| q_val_i | input | QW | Raw increment q for the row on `q_row_o` |
| idx_valid_o | output | 1 | An index is present this cycle |
| idx_row_o | output | RW | Row number of the present index |
| idx_col_o | output | PW | Permuted column index |
| done_o | output | 1 | One-cycle pulse after the last index |

## Verification
The end of one job and the acceptance of the next can meet in a single cycle. The bench raises start, with a fresh configuration, in exactly the cycle where `done_o` is seen high. It then judges the following job index by index against the fresh configuration. It also checks that `done_o` was a one-cycle pulse with no valid beat beside it. The opposite collision, a start strobe landing mid-stream with altered inputs, is provoked on a chosen beat. The full stream is then compared unchanged against the original configuration.

// File: rtl/iam_pkg.sv
package iam_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SGEN = 3'd1,
      ST_QRED = 3'd2,
      ST_RUN  = 3'd3,
      ST_FIN  = 3'd4
   } iam_state_e;

endpackage

// File: rtl/iam_sbase_gen.sv
// Bit-serial generator of s(k) = v*s(k-1) mod p, one table word every PW cycles.
module iam_sbase_gen #(
   parameter int PW = 9,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [PW-1:0] prime_i,
   input  logic [PW-1:0] root_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [PW-1:0] wr_data_o,
   output logic          fin_o
);

   localparam int BW = (PW > 1) ? $clog2(PW) : 1;

   logic          active_q;
   logic [AW-1:0] k_q;
   logic [BW-1:0] bit_q;
   logic [PW-1:0] acc_q;
   logic [PW-1:0] cur_q;
   logic [PW-1:0] dbl;
   logic [PW-1:0] acc_n;

   function automatic logic [PW-1:0] mod_sum(input logic [PW-1:0] a,
                                             input logic [PW-1:0] b,
                                             input logic [PW-1:0] m);
      logic [PW:0] t;
      t = {1'b0, a} + {1'b0, b};
      if (t >= {1'b0, m}) t = t - {1'b0, m};
      return t[PW-1:0];
   endfunction

   always_comb begin
      dbl   = mod_sum(acc_q, acc_q, prime_i);
      acc_n = root_i[bit_q] ? mod_sum(dbl, cur_q, prime_i) : dbl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         k_q       <= '0;
         bit_q     <= '0;
         acc_q     <= '0;
         cur_q     <= '0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         fin_o     <= 1'b0;
      end else begin
         wr_en_o <= 1'b0;
         fin_o   <= 1'b0;
         if (go_i) begin
            active_q  <= 1'b1;
            wr_en_o   <= 1'b1;
            wr_addr_o <= '0;
            wr_data_o <= PW'(1);
            cur_q     <= PW'(1);
            k_q       <= AW'(1);
            acc_q     <= '0;
            bit_q     <= BW'(PW - 1);
         end else if (active_q) begin
            if (bit_q == '0) begin
               wr_en_o   <= 1'b1;
               wr_addr_o <= k_q;
               wr_data_o <= acc_n;
               cur_q     <= acc_n;
               acc_q     <= '0;
               bit_q     <= BW'(PW - 1);
               if (PW'(k_q) == prime_i - PW'(2)) begin
                  active_q <= 1'b0;
                  fin_o    <= 1'b1;
               end else begin
                  k_q <= k_q + AW'(1);
               end
            end else begin
               acc_q <= acc_n;
               bit_q <= bit_q - BW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/iam_sram.sv
// Base-sequence table: registered write, combinational read.
module iam_sram #(
   parameter int PW    = 9,
   parameter int AW    = 8,
   parameter int DEPTH = 256
) (
   input  logic          clk,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [PW-1:0] wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [PW-1:0] rd_data_o
);

   logic [PW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/iam_qred.sv
// Reduces a raw increment modulo m by one subtraction per cycle.
module iam_qred #(
   parameter int QW = 9,
   parameter int PW = 9,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [QW-1:0] q_i,
   input  logic [PW-1:0] mod_i,
   output logic          ready_o,
   output logic [AW-1:0] res_o
);

   logic          active_q;
   logic [QW-1:0] rem_q;
   logic [QW-1:0] m_ext;

   assign m_ext = QW'(mod_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rem_q    <= '0;
         ready_o  <= 1'b0;
         res_o    <= '0;
      end else begin
         ready_o <= 1'b0;
         if (go_i) begin
            active_q <= 1'b1;
            rem_q    <= q_i;
         end else if (active_q) begin
            if (rem_q >= m_ext) begin
               rem_q <= rem_q - m_ext;
            end else begin
               active_q <= 1'b0;
               ready_o  <= 1'b1;
               res_o    <= rem_q[AW-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/iam_row_ring.sv
// Per-row running table address and reduced increment.
module iam_row_ring #(
   parameter int MAX_ROWS = 20,
   parameter int RW       = 5,
   parameter int AW       = 8,
   parameter int PW       = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_en_i,
   input  logic          step_en_i,
   input  logic [RW-1:0] row_i,
   input  logic [AW-1:0] init_qm_i,
   input  logic [PW-1:0] mod_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] addr_vec [MAX_ROWS];

   for (genvar e = 0; e < MAX_ROWS; e++) begin : g_row
      logic [AW-1:0] a_q;
      logic [AW-1:0] qm_q;
      logic [PW:0]   sum;
      logic [AW-1:0] nxt;

      always_comb begin
         sum = {1'b0, PW'(a_q)} + {1'b0, PW'(qm_q)};
         if (sum >= {1'b0, mod_i}) sum = sum - {1'b0, mod_i};
         nxt = sum[AW-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q  <= '0;
            qm_q <= '0;
         end else if (init_en_i && row_i == RW'(e)) begin
            a_q  <= '0;
            qm_q <= init_qm_i;
         end else if (step_en_i && row_i == RW'(e)) begin
            a_q <= nxt;
         end
      end

      assign addr_vec[e] = a_q;
   end

   assign addr_o = addr_vec[row_i];

endmodule

// File: rtl/iam_addr_gen.sv
module iam_addr_gen
   import iam_pkg::*;
#(
   parameter  int MAX_P    = 257,
   parameter  int MAX_ROWS = 20,
   parameter  int QW       = 9,
   localparam int PW       = $clog2(MAX_P + 1),
   localparam int AW       = $clog2(MAX_P - 1),
   localparam int CW       = $clog2(MAX_P + 2),
   localparam int RW       = $clog2(MAX_ROWS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [PW-1:0] prime_i,
   input  logic [PW-1:0] root_i,
   input  logic [RW-1:0] rows_i,
   input  logic [CW-1:0] cols_i,
   output logic [RW-1:0] q_row_o,
   input  logic [QW-1:0] q_val_i,
   output logic          idx_valid_o,
   output logic [RW-1:0] idx_row_o,
   output logic [PW-1:0] idx_col_o,
   output logic          done_o
);

   localparam int SDEPTH = MAX_P - 1;

   if (MAX_P < 5) begin : g_chk_p
      $error("iam_addr_gen: MAX_P must be at least 5");
   end
   if (MAX_ROWS < 1) begin : g_chk_r
      $error("iam_addr_gen: MAX_ROWS must be at least 1");
   end
   if (QW < PW) begin : g_chk_q
      $error("iam_addr_gen: QW must not be narrower than PW");
   end

   iam_state_e    st_q;
   logic [PW-1:0] p_q, v_q;
   logic [RW-1:0] rows_q, row_q;
   logic [CW-1:0] cols_q, col_q;
   logic          sgo_q, qgo_q;
   logic [PW-1:0] modulus;

   logic          s_wen, s_fin, q_ready;
   logic [AW-1:0] s_waddr, q_res, ring_addr;
   logic [PW-1:0] s_wdata, s_rdata;
   logic          init_en, step_en;

   assign modulus = p_q - PW'(1);
   assign init_en = (st_q == ST_QRED) && q_ready;
   assign step_en = (st_q == ST_RUN);
   assign q_row_o = row_q;

   iam_sbase_gen #(.PW(PW), .AW(AW)) u_sgen (
      .clk(clk), .rst_n(rst_n), .go_i(sgo_q),
      .prime_i(p_q), .root_i(v_q),
      .wr_en_o(s_wen), .wr_addr_o(s_waddr), .wr_data_o(s_wdata),
      .fin_o(s_fin)
   );

   iam_sram #(.PW(PW), .AW(AW), .DEPTH(SDEPTH)) u_stab (
      .clk(clk), .wr_en_i(s_wen), .wr_addr_i(s_waddr), .wr_data_i(s_wdata),
      .rd_addr_i(ring_addr), .rd_data_o(s_rdata)
   );

   iam_qred #(.QW(QW), .PW(PW), .AW(AW)) u_qred (
      .clk(clk), .rst_n(rst_n), .go_i(qgo_q), .q_i(q_val_i),
      .mod_i(modulus), .ready_o(q_ready), .res_o(q_res)
   );

   iam_row_ring #(.MAX_ROWS(MAX_ROWS), .RW(RW), .AW(AW), .PW(PW)) u_ring (
      .clk(clk), .rst_n(rst_n), .init_en_i(init_en), .step_en_i(step_en),
      .row_i(row_q), .init_qm_i(q_res), .mod_i(modulus), .addr_o(ring_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         p_q         <= PW'(5);
         v_q         <= '0;
         rows_q      <= RW'(1);
         cols_q      <= CW'(1);
         row_q       <= '0;
         col_q       <= '0;
         sgo_q       <= 1'b0;
         qgo_q       <= 1'b0;
         idx_valid_o <= 1'b0;
         idx_row_o   <= '0;
         idx_col_o   <= '0;
         done_o      <= 1'b0;
      end else begin
         sgo_q       <= 1'b0;
         qgo_q       <= 1'b0;
         idx_valid_o <= 1'b0;
         done_o      <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  p_q    <= prime_i;
                  v_q    <= root_i;
                  rows_q <= rows_i;
                  cols_q <= cols_i;
                  sgo_q  <= 1'b1;
                  st_q   <= ST_SGEN;
               end
            end
            ST_SGEN: begin
               if (s_fin) begin
                  row_q <= '0;
                  qgo_q <= 1'b1;
                  st_q  <= ST_QRED;
               end
            end
            ST_QRED: begin
               if (q_ready) begin
                  if (row_q == rows_q - RW'(1)) begin
                     row_q <= '0;
                     col_q <= '0;
                     st_q  <= ST_RUN;
                  end else begin
                     row_q <= row_q + RW'(1);
                     qgo_q <= 1'b1;
                  end
               end
            end
            ST_RUN: begin
               idx_valid_o <= 1'b1;
               idx_row_o   <= row_q;
               idx_col_o   <= s_rdata;
               if (row_q == rows_q - RW'(1)) begin
                  row_q <= '0;
                  if (col_q == cols_q - CW'(1)) st_q <= ST_FIN;
                  else                          col_q <= col_q + CW'(1);
               end else begin
                  row_q <= row_q + RW'(1);
               end
            end
            ST_FIN: begin
               done_o <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/iam_addr_gen_chk.sv
module iam_addr_gen_chk #(
   parameter int PW = 9,
   parameter int RW = 5,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy,
   input logic          in_run,
   input logic          idx_valid,
   input logic [RW-1:0] idx_row,
   input logic [PW-1:0] idx_col,
   input logic          done,
   input logic [PW-1:0] p_q,
   input logic [RW-1:0] rows_q,
   input logic [AW-1:0] ring_addr,
   input logic [PW-1:0] modulus
);

   // R2
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> (idx_col != '0 && idx_col < p_q));

   // R3
   ring_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_run |-> (PW'(ring_addr) < modulus));

   // R4
   row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && $past(idx_valid)) |->
         (idx_row == (($past(idx_row) == rows_q - RW'(1)) ? RW'(0) : $past(idx_row) + RW'(1))));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!idx_valid && $past(idx_valid)));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> ($stable(rows_q) && $stable(p_q)));

endmodule

bind iam_addr_gen iam_addr_gen_chk #(.PW(PW), .RW(RW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .busy(st_q != iam_pkg::ST_IDLE), .in_run(st_q == iam_pkg::ST_RUN),
   .idx_valid(idx_valid_o), .idx_row(idx_row_o), .idx_col(idx_col_o),
   .done(done_o), .p_q(p_q), .rows_q(rows_q), .ring_addr(ring_addr),
   .modulus(modulus)
);

// File: tb/iam_addr_gen_tb.sv
`timescale 1ns/1ps
module iam_addr_gen_tb;

   localparam int PW = 9, RW = 5, CW = 9, QW = 9;
   localparam int NCFG = 6;
   // prime, root, rows, cols
   localparam int CFG [NCFG][4] = '{
      '{7,   3, 5,  6},
      '{5,   2, 1,  1},
      '{11,  2, 10, 12},
      '{13,  2, 5,  14},
      '{17,  3, 20, 16},
      '{257, 3, 20, 258}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [PW-1:0] prime_i = '0;
   logic [PW-1:0] root_i = '0;
   logic [RW-1:0] rows_i = '0;
   logic [CW-1:0] cols_i = '0;
   logic [RW-1:0] q_row_o;
   logic [QW-1:0] q_val_i;
   logic          idx_valid_o;
   logic [RW-1:0] idx_row_o;
   logic [PW-1:0] idx_col_o;
   logic          done_o;

   int checks = 0, fails = 0, cycles = 0;
   int cur_p = 7;
   int sx [0:300];

   always #2.5 clk = ~clk;

   iam_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .prime_i(prime_i),
      .root_i(root_i), .rows_i(rows_i), .cols_i(cols_i), .q_row_o(q_row_o),
      .q_val_i(q_val_i), .idx_valid_o(idx_valid_o), .idx_row_o(idx_row_o),
      .idx_col_o(idx_col_o), .done_o(done_o)
   );

   function automatic int qfun(int p, int i);
      if (i == 0) return 0;
      if (i == 1) return p - 1;
      if (i == 2) return 2 * (p - 1);
      if (i == 3) return 511;
      return (i * 37 + p * 11) % 512;
   endfunction

   // R10: raw increment follows the requested row
   always_comb q_val_i = QW'(qfun(cur_p, int'(q_row_o)));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic launch(input int p, input int v, input int r, input int c);
      prime_i = PW'(p); root_i = PW'(v); rows_i = RW'(r); cols_i = CW'(c);
      cur_p = p;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Collects one job; returns at the negedge where done should be visible.
   task automatic collect(input int p, input int v, input int r, input int c,
                          input int poke_at);
      int waited = 0;
      sx[0] = 1;
      for (int k = 1; k < p - 1; k++) sx[k] = (v * sx[k-1]) % p;
      while (!idx_valid_o && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk(idx_valid_o, "R5 first index", int'(idx_valid_o), 1);
      for (int n = 0; n < r * c; n++) begin
         int i, j, qm, a, e;
         string tag;
         if (n > 0) @(negedge clk);
         start_i = 1'b0;
         i  = n % r;
         j  = n / r;
         qm = qfun(p, i) % (p - 1);
         a  = (j * qm) % (p - 1);
         e  = sx[a];
         if (qm == 0)      tag = "R3";
         else if (j >= p - 1) tag = "R9";
         else              tag = "R2";
         chk(idx_valid_o, "R5 valid run", int'(idx_valid_o), 1);
         chk(int'(idx_row_o) == i, "R4 row order", int'(idx_row_o), i);
         chk(int'(idx_col_o) == e, tag, int'(idx_col_o), e);
         if (n == poke_at) begin
            // R7: start with altered configuration in mid-run
            start_i = 1'b1; prime_i = PW'(5); rows_i = RW'(1); cols_i = CW'(1);
         end
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R6 done high", int'(done_o), 1);
      chk(idx_valid_o == 1'b0, "R6 valid low with done", int'(idx_valid_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!idx_valid_o && !done_o, "R1 in reset", int'(idx_valid_o) + int'(done_o), 0);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk(!idx_valid_o && !done_o, "R1 idle", int'(idx_valid_o) + int'(done_o), 0);
      end

      for (int t = 0; t < NCFG; t++) begin
         launch(CFG[t][0], CFG[t][1], CFG[t][2], CFG[t][3]);
         collect(CFG[t][0], CFG[t][1], CFG[t][2], CFG[t][3], -1);
         @(negedge clk);
         chk(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
      end

      // R7: start ignored during a run
      launch(CFG[3][0], CFG[3][1], CFG[3][2], CFG[3][3]);
      collect(CFG[3][0], CFG[3][1], CFG[3][2], CFG[3][3], 7);
      @(negedge clk);
      chk(done_o == 1'b0 && idx_valid_o == 1'b0, "R7 no extra job",
          int'(done_o) + int'(idx_valid_o), 0);
      repeat (3000) @(negedge clk);
      chk(idx_valid_o == 1'b0, "R7 no restart", int'(idx_valid_o), 0);

      // R8: start during the done cycle with a fresh configuration
      launch(CFG[2][0], CFG[2][1], CFG[2][2], CFG[2][3]);
      collect(CFG[2][0], CFG[2][1], CFG[2][2], CFG[2][3], -1);
      prime_i = PW'(CFG[4][0]); root_i = PW'(CFG[4][1]);
      rows_i = RW'(CFG[4][2]);  cols_i = CW'(CFG[4][3]);
      cur_p = CFG[4][0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
      collect(CFG[4][0], CFG[4][1], CFG[4][2], CFG[4][3], -1);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 job closed", int'(done_o), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule